// File: doc/BRIEF.md
# Parity Error Counter with Requested Snapshot

This block watches a cell-bus data input and counts the words whose parity is wrong. On each clock it samples a data word, a parity bit and a valid strobe. When the strobe is high it checks the parity against the configured sense. Any mismatch advances a 12-bit error counter that wraps around.

Software never reads the live counter. It writes a transfer request into a 16-bit control and status word. A small transfer machine then copies the counter into a snapshot field and raises a completion bit. The same word holds:

- a control bit that keeps the counter at zero;
- a sticky flag that records that some error occurred;
- a sticky flag that records that the counter wrapped.

Software clears either sticky flag by writing 0 to it.

The transfer machine has three states:

- `XS_IDLE`: no transfer has happened since reset. The completion bit reads 0.
- `XS_PEND`: a request has been taken and the copy has not yet landed. The completion bit reads 0.
- `XS_DONE`: the snapshot holds the requested value. The completion bit reads 1.

The transitions are:

- `XS_IDLE` to `XS_PEND` on a request.
- `XS_DONE` to `XS_PEND` on a request.
- `XS_PEND` to `XS_PEND` on a repeated request. This re-captures the counter.
- `XS_PEND` to `XS_DONE` on the next clock with no request. The snapshot is loaded at that edge.
- Reset returns the machine to `XS_IDLE`.

Top module: `parity_err_snap`

## Requirements

- R1: Bits 11:0 of the register change only at the clock edge where a pending transfer completes. Writes to bits 11:0 are ignored, and parity errors alone never alter them.
- R2: A write with bit 13 set captures the counter as it stood before that cycle's parity error, if one occurs. An error in the request cycle is still counted afterwards. A write with bit 13 clear requests nothing.
- R3: Bit 13 reads 0 after reset and in the cycle after the request edge. It reads 1 from the second edge after the request, once the snapshot is valid.
- R4: Bit 12 is a read/write control. While it reads 1 the counter is held at zero and errors are not counted.
- R5: Parity is checked only while valid is high. With odd sense (the default), an error is a word whose data bits plus parity bit hold an even number of ones. With even sense, an error is a word whose total is odd.
- R6: Bit 14 is set by any detected parity error, including one seen while the counter is held. Writing 0 to bit 14 clears it. Writing 1 to bit 14 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: Bit 15 is set when the counter wraps from 4095 to 0. The counter then reads 0. Bit 15 is cleared by writing 0 to it, and writing 1 leaves it unchanged.
- R8: After reset the whole register reads 0x0000.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Cell-bus data word |
| din_par | input | 1 | Parity bit for din |
| din_vld | input | 1 | Data valid strobe; parity is checked only when high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value {wrap, seen, done, hold, snapshot} |

## Verification

The hardest state to reach from the ports is the wrap flag. It needs 4096 counted errors with no hold in between. The stimulus first zeroes the counter through the hold bit. It then streams 4095 bad words and takes a snapshot, which must read 4095 with the wrap flag still clear. One more bad word must then give a snapshot of 0 with the flag set.

The second delicate case is a bad word that arrives in the same cycle as a transfer request. The bench drives both together. It checks that the snapshot excludes that error and that the following snapshot includes it.

// File: rtl/pes_pkg.sv
package pes_pkg;

    // Field positions inside the control/status word
    localparam int REG_W    = 16;
    localparam int SNAP_W   = 12;
    localparam int BIT_ROLL = 15;
    localparam int BIT_SEEN = 14;
    localparam int BIT_XFER = 13;
    localparam int BIT_HOLD = 12;

    // Snapshot transfer machine
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_PEND = 2'd1,
        XS_DONE = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/pes_check.sv
module pes_check #(
    parameter int DATA_W     = 8,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              din_par,
    input  logic              din_vld,
    output logic              err
);

    logic ones_odd;

    // XOR of data and parity: 1 when the total count of ones is odd
    assign ones_odd = ^{din, din_par};

    generate
        if (ODD_PARITY) begin : g_odd
            assign err = din_vld & ~ones_odd;
        end else begin : g_even
            assign err = din_vld & ones_odd;
        end
    endgenerate

    // R5: an invalid cycle never flags an error
    assert_quiet_when_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        !din_vld |-> !err);

endmodule

// File: rtl/pes_counter.sv
module pes_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= '0;
        end else if (err) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap = err & ~hold & (cnt == CNT_MAX);

    // R4: holding forces the count to zero
    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0));

    // R7: a wrap lands the count at zero
    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/pes_xfer.sv
module pes_xfer
    import pes_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt_live,
    output logic [CNT_W-1:0] snap,
    output logic             done
);

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] latch_q;
    logic             load;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (req) state_d = XS_PEND;
            XS_PEND: state_d = req ? XS_PEND : XS_DONE;
            XS_DONE: if (req) state_d = XS_PEND;
            default: state_d = XS_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        done = (state_q == XS_DONE);
        load = (state_q == XS_PEND) && !req;
    end

    // Capture on request, publish on completion
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            snap    <= '0;
        end else begin
            if (req) begin
                latch_q <= cnt_live;
            end
            if (load) begin
                snap <= latch_q;
            end
        end
    end

    // R2: a request always leads to the pending state
    assert_req_pending_R2: assert property (@(posedge clk) disable iff (rst)
        req |=> (state_q == XS_PEND) && !done);

    // R3: completion follows a pending cycle without a new request
    assert_done_follows_R3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == XS_PEND) && !req) |=> done);

    // R1: the snapshot moves only out of the pending state
    assert_snap_steady_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q != XS_PEND) |=> $stable(snap));

endmodule

// File: rtl/parity_err_snap.sv
module parity_err_snap
    import pes_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 12,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              din_par,
    input  logic              din_vld,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data
);

    logic              err;
    logic              wrap;
    logic              req;
    logic              done;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  snap;
    logic [SNAP_W-1:0] snap_ext;
    logic              hold_q, seen_q, roll_q;
    logic              clr_seen, clr_roll;

    pes_check #(
        .DATA_W    (DATA_W),
        .ODD_PARITY(ODD_PARITY)
    ) u_check (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .din_par(din_par),
        .din_vld(din_vld),
        .err    (err)
    );

    pes_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk (clk),
        .rst (rst),
        .err (err),
        .hold(hold_q),
        .cnt (cnt),
        .wrap(wrap)
    );

    assign req = wr_en & wr_data[BIT_XFER];

    pes_xfer #(
        .CNT_W(CNT_W)
    ) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .cnt_live(cnt),
        .snap    (snap),
        .done    (done)
    );

    assign clr_seen = wr_en & ~wr_data[BIT_SEEN];
    assign clr_roll = wr_en & ~wr_data[BIT_ROLL];

    // Control bit and sticky flags; hardware set wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            seen_q <= 1'b0;
            roll_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data[BIT_HOLD];
            end
            seen_q <= err  | (seen_q & ~clr_seen);
            roll_q <= wrap | (roll_q & ~clr_roll);
        end
    end

    always_comb begin
        snap_ext              = '0;
        snap_ext[CNT_W-1:0]   = snap;
        rd_data               = '0;
        rd_data[SNAP_W-1:0]   = snap_ext;
        rd_data[BIT_HOLD]     = hold_q;
        rd_data[BIT_XFER]     = done;
        rd_data[BIT_SEEN]     = seen_q;
        rd_data[BIT_ROLL]     = roll_q;
    end

    // R8: the register is cleared by reset
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R6: an error sets the seen flag
    assert_seen_set_R6: assert property (@(posedge clk) disable iff (rst)
        err |=> rd_data[BIT_SEEN]);

    // R6: the seen flag stays set without a zero write
    assert_seen_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[BIT_SEEN] && !clr_seen) |=> rd_data[BIT_SEEN]);

    // R7: a wrap sets the rollover flag
    assert_roll_set_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> rd_data[BIT_ROLL]);

endmodule

// File: tb/tb_parity_err_snap.sv
module tb_parity_err_snap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  din = '0;
    logic        din_par = 1'b0;
    logic        din_vld = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int mcount = 0;

    always #5 clk = ~clk;

    parity_err_snap dut (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .din_par(din_par),
        .din_vld(din_vld),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data)
    );

    // {din, parity, valid, expected error under odd sense}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {8'h00, 1'b1, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b1, 1'b1},
        {8'h01, 1'b0, 1'b1, 1'b0},
        {8'h03, 1'b0, 1'b1, 1'b1},
        {8'hFF, 1'b0, 1'b1, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b0},
        {8'h00, 1'b0, 1'b0, 1'b0},
        {8'hA5, 1'b1, 1'b1, 1'b0},
        {8'hA5, 1'b0, 1'b1, 1'b1},
        {8'h7F, 1'b0, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        tick();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // request keeping both flags and clearing hold, then wait for completion
    task automatic snapshot();
        reg_write(16'hE000);
        tick();
    endtask

    task automatic bad_words(input int n);
        din     = 8'h00;
        din_par = 1'b0;
        din_vld = 1'b1;
        repeat (n) tick();
        din_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        // R8 reset value, R3 no completion yet
        chk(rd_data == 16'h0000, "R8", rd_data, 16'h0000);
        chk(rd_data[13] == 1'b0, "R3", rd_data[13], 0);

        // Vector walk: R5 parity rule, R1/R2 snapshot of the running count
        for (int i = 0; i < NV; i++) begin
            din     = VEC[i][10:3];
            din_par = VEC[i][2];
            din_vld = VEC[i][1];
            mcount  = mcount + int'(VEC[i][0]);
            tick();
            din_vld = 1'b0;
            snapshot();
            chk(rd_data[11:0] == mcount[11:0] && rd_data[13], "R5",
                rd_data[11:0], mcount);
            chk(rd_data[14] == (mcount > 0), "R6", rd_data[14], (mcount > 0));
        end

        // R3 pending then complete
        reg_write(16'hE000);
        chk(rd_data[13] == 1'b0, "R3", rd_data[13], 0);
        tick();
        chk(rd_data[13] == 1'b1, "R3", rd_data[13], 1);

        // R2 error in the request cycle is excluded, then counted
        din = 8'h00; din_par = 1'b0; din_vld = 1'b1;
        wr_en = 1'b1; wr_data = 16'hE000;
        tick();
        din_vld = 1'b0; wr_en = 1'b0; wr_data = '0;
        tick();
        chk(rd_data[11:0] == mcount[11:0], "R2", rd_data[11:0], mcount);
        mcount++;
        snapshot();
        chk(rd_data[11:0] == mcount[11:0], "R2", rd_data[11:0], mcount);

        // R1 errors and low-field writes leave the snapshot alone
        bad_words(3);
        chk(rd_data[11:0] == mcount[11:0], "R1", rd_data[11:0], mcount);
        reg_write(16'hC0FF);
        tick();
        chk(rd_data[11:0] == mcount[11:0], "R1", rd_data[11:0], mcount);
        mcount += 3;
        snapshot();
        chk(rd_data[11:0] == mcount[11:0], "R1", rd_data[11:0], mcount);

        // R6 writing 1 keeps the seen flag, writing 0 clears it, error sets it
        reg_write(16'h4000);
        chk(rd_data[14] == 1'b1, "R6", rd_data[14], 1);
        reg_write(16'h8000);
        chk(rd_data[14] == 1'b0, "R6", rd_data[14], 0);
        bad_words(1);
        mcount++;
        chk(rd_data[14] == 1'b1, "R6", rd_data[14], 1);

        // R4 hold keeps the counter at zero
        reg_write(16'hD000);
        chk(rd_data[12] == 1'b1, "R4", rd_data[12], 1);
        bad_words(5);
        snapshot();
        mcount = 0;
        chk(rd_data[11:0] == 12'd0 && rd_data[12] == 1'b0, "R4", rd_data[12:0], 0);

        // R7 wrap after 4096 errors
        bad_words(4095);
        mcount = 4095;
        snapshot();
        chk(rd_data[11:0] == 12'hFFF && !rd_data[15], "R7", rd_data, 16'h6FFF);
        bad_words(1);
        snapshot();
        chk(rd_data[11:0] == 12'd0 && rd_data[15], "R7", rd_data, 16'hE000);
        reg_write(16'hC000);
        chk(rd_data[15] == 1'b1, "R7", rd_data[15], 1);
        reg_write(16'h4000);
        chk(rd_data[15] == 1'b0 && rd_data[14], "R7", rd_data[15:14], 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule